// File: doc/BRIEF.md
# DMA Channel Arming and Descriptor Loader

This block sits in front of a DMA transfer engine and prepares its channels. Software arms or aborts channels through a single arm/abort register. It also programs two 16-bit descriptor base pointers. Channel 0 has a base pointer of its own. Channels 1 to 4 share the second one, and their four 8-byte descriptors lie back to back from that address.

When a channel is armed, the block works out where that channel's descriptor sits. It reads the eight bytes through a byte-wide memory read port and latches the decoded fields. It then raises the channel's ready flag, which tells the transfer engine it may use the channel. Fetches are handled one channel at a time, and the lowest-numbered pending channel goes first.

An abort write disarms the channels it selects and clears their ready flags. If the channel whose descriptor is being read is aborted, that fetch is cancelled. Descriptor byte layout (little-endian):

| Byte | Meaning |
|---|---|
| 0–1 | source address |
| 2–3 | destination address |
| 4 | length byte |
| 5 | config byte: bit 0 = word mode (1 = 16-bit, 0 = 8-bit); bit 1 = full-length flag |
| 6–7 | read but ignored |

Top module: `dma_desc_loader`

## Requirements
- R1: After reset, `ch_armed` and `ch_ready` are all zero and `mem_req` is low.
- R2: A write with `reg_wr_sel` = 0 and `reg_wr_data[7]` = 0 sets `ch_armed[n]` for every `n` whose `reg_wr_data[n]` is 1, and leaves the other channels' armed bits unchanged.
- R3: The descriptor of channel 0 is read from addresses `B0`..`B0+7`, where `B0` is the value last written with `reg_wr_sel` = 1.
- R4: The descriptor of channel `n` (1..4) is read from `BG+8*(n-1)` onward, where `BG` is the value last written with `reg_wr_sel` = 2.
- R5: During a fetch, `mem_req` stays high and `mem_addr` holds its value on cycles without `mem_gnt`. Each granted cycle consumes `mem_rdata` and advances `mem_addr` by one, for exactly eight granted bytes per descriptor.
- R6: Only one descriptor is fetched at a time. When several channels are pending, the lowest channel number is fetched first.
- R7: The cycle after the eighth byte is granted, the channel's ready flag rises. `ch_src` then holds bytes 0–1 and `ch_dst` holds bytes 2–3, both little-endian. `ch_word` equals config bit 0.
- R8: `ch_len` equals the full length byte in word mode, or in byte mode when config bit 1 is 1. In byte mode with config bit 1 equal to 0, it equals the low 7 bits of the length byte with bit 7 cleared.
- R9: A write with `reg_wr_sel` = 0 and `reg_wr_data[7]` = 1 clears armed and ready for every channel whose bit is 1 in that write. It leaves all other channels unchanged.
- R10: An abort of the channel being fetched drops `mem_req` in the next cycle and leaves that channel not ready. A later re-arm fetches its descriptor again from byte 0.
- R11: A channel's ready flag is never set while its armed flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 arm/abort, 1 channel-0 base, 2 shared base |
| reg_wr_data | input | 16 | Write data; arm/abort uses bits 4:0 as channel mask and bit 7 as abort |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 16 | Descriptor byte address |
| mem_gnt | input | 1 | Grant; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 8 | Read data byte |
| ch_armed | output | 5 | Per-channel armed flags |
| ch_ready | output | 5 | Per-channel descriptor-loaded flags |
| ch_word | output | 5 | Per-channel word-mode flag |
| ch_src | output | 80 | Per-channel source address, channel n at bits 16n+15:16n |
| ch_dst | output | 80 | Per-channel destination address, same packing |
| ch_len | output | 40 | Per-channel effective length, channel n at bits 8n+7:8n |

## Verification
The bench uses the default build: five channels, 16-bit addresses, abort flag at bit 7. With this build, both addressing paths are reachable: channel 0 through its own pointer, and the shared pointer at offsets 0, 8, 16 and 24, including one pointer that is not aligned to eight bytes. The five channels are enough to queue three at once and confirm the lowest-first order, and to abort one channel mid-fetch while its neighbours stay loaded. Fetches alternate between a continuous grant and a grant every other cycle, so stalled address holding is exercised as well.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  localparam int DESC_BYTES     = 8;
  localparam int CFG_WORD_BIT   = 0;
  localparam int CFG_FULLEN_BIT = 1;

  typedef enum logic [1:0] {
    SEL_ARM        = 2'd0,
    SEL_BASE_SOLO  = 2'd1,
    SEL_BASE_GROUP = 2'd2
  } reg_sel_e;

  // byte i of the descriptor lands at bits 8i+7:8i
  typedef struct packed {
    logic [7:0]  pad7;
    logic [7:0]  pad6;
    logic [7:0]  cfg;
    logic [7:0]  len;
    logic [15:0] dst;
    logic [15:0] src;
  } desc_t;

  function automatic logic [7:0] eff_len(input desc_t d);
    if (d.cfg[CFG_WORD_BIT] || d.cfg[CFG_FULLEN_BIT])
      return d.len;
    return {1'b0, d.len[6:0]};
  endfunction

endpackage

// File: rtl/dma_arm_ctrl.sv
module dma_arm_ctrl #(
  parameter int NUM_CH    = 5,
  parameter int DW        = 16,
  parameter int ABORT_BIT = 7,
  parameter int CW        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_wr,
  input  logic [DW-1:0]     wr_data,
  input  logic              done,
  input  logic [CW-1:0]     done_ch,
  output logic [NUM_CH-1:0] armed,
  output logic [NUM_CH-1:0] ready,
  output logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] kill_vec
);

  logic [NUM_CH-1:0] armed_q, armed_d, ready_q, ready_d;
  logic [NUM_CH-1:0] set_vec, done_vec, mask;
  logic              abort, upd_en;

  always_comb begin
    mask     = wr_data[NUM_CH-1:0];
    abort    = wr_data[ABORT_BIT];
    kill_vec = (arm_wr && abort)  ? mask : '0;
    set_vec  = (arm_wr && !abort) ? mask : '0;
    for (int i = 0; i < NUM_CH; i++)
      done_vec[i] = done && (done_ch == CW'(i));
    armed_d  = (armed_q | set_vec) & ~kill_vec;
    ready_d  = (ready_q | done_vec) & ~kill_vec;
    upd_en   = arm_wr || done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= '0;
      ready_q <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      ready_q <= ready_d;
    end
  end

  assign armed   = armed_q;
  assign ready   = ready_q;
  assign pending = armed_q & ~ready_q & ~kill_vec;

endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_desc_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int AW     = 16,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pending,
  input  logic [NUM_CH-1:0] kill_vec,
  input  logic [AW-1:0]     base_solo,
  input  logic [AW-1:0]     base_group,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [CW-1:0]     done_ch,
  output logic [2:0]        byte_idx,
  output desc_t             desc
);

  logic          busy_q, busy_d;
  logic [CW-1:0] ch_q, ch_d, pick;
  logic [2:0]    idx_q, idx_d;
  logic [AW-1:0] start_q, start_d, start_pick, grp_off;
  logic [63:0]   buf_q, buf_d;
  logic          found, killed, last, cap_en;

  // lowest pending channel wins
  always_comb begin
    pick  = '0;
    found = |pending;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pending[i]) pick = CW'(i);
    grp_off    = ({{(AW-CW){1'b0}}, pick} - AW'(1)) << 3;
    start_pick = (pick == '0) ? base_solo : base_group + grp_off;
  end

  always_comb begin
    killed = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_q == CW'(i)) killed = kill_vec[i];
  end

  assign last     = (idx_q == 3'd7);
  assign mem_req  = busy_q;
  assign mem_addr = start_q + AW'(idx_q);
  assign done     = busy_q && mem_gnt && last && !killed;
  assign done_ch  = ch_q;
  assign byte_idx = idx_q;
  assign desc     = desc_t'({mem_rdata, buf_q[55:0]});
  assign cap_en   = busy_q && mem_gnt && !killed;

  always_comb begin
    busy_d  = busy_q;
    ch_d    = ch_q;
    idx_d   = idx_q;
    start_d = start_q;
    buf_d   = buf_q;
    if (busy_q) begin
      if (killed) begin
        busy_d = 1'b0;
      end else if (mem_gnt) begin
        buf_d[{idx_q, 3'b000} +: 8] = mem_rdata;
        idx_d = idx_q + 3'd1;
        if (last) busy_d = 1'b0;
      end
    end else if (found) begin
      busy_d  = 1'b1;
      ch_d    = pick;
      idx_d   = 3'd0;
      start_d = start_pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ch_q    <= '0;
      idx_q   <= '0;
      start_q <= '0;
    end else begin
      busy_q  <= busy_d;
      ch_q    <= ch_d;
      idx_q   <= idx_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (cap_en) buf_q <= buf_d;
  end

endmodule

// File: rtl/dma_desc_store.sv
module dma_desc_store
  import dma_desc_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int AW     = 16,
  parameter int CW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [CW-1:0]        done_ch,
  input  desc_t                desc,
  output logic [NUM_CH*AW-1:0] src_flat,
  output logic [NUM_CH*AW-1:0] dst_flat,
  output logic [NUM_CH*8-1:0]  len_flat,
  output logic [NUM_CH-1:0]    word
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic          ld_en;
    logic [AW-1:0] src_q, dst_q;
    logic [7:0]    len_q;
    logic          word_q;

    assign ld_en = done && (done_ch == CW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q  <= '0;
        dst_q  <= '0;
        len_q  <= '0;
        word_q <= 1'b0;
      end else if (ld_en) begin
        src_q  <= AW'(desc.src);
        dst_q  <= AW'(desc.dst);
        len_q  <= eff_len(desc);
        word_q <= desc.cfg[CFG_WORD_BIT];
      end
    end

    assign src_flat[g*AW +: AW] = src_q;
    assign dst_flat[g*AW +: AW] = dst_q;
    assign len_flat[g*8 +: 8]   = len_q;
    assign word[g]              = word_q;
  end

endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
  import dma_desc_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int AW        = 16,
  parameter int ABORT_BIT = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [1:0]           reg_wr_sel,
  input  logic [AW-1:0]        reg_wr_data,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_gnt,
  input  logic [7:0]           mem_rdata,
  output logic [NUM_CH-1:0]    ch_armed,
  output logic [NUM_CH-1:0]    ch_ready,
  output logic [NUM_CH-1:0]    ch_word,
  output logic [NUM_CH*AW-1:0] ch_src,
  output logic [NUM_CH*AW-1:0] ch_dst,
  output logic [NUM_CH*8-1:0]  ch_len
);

  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [AW-1:0]     base_solo_q, base_group_q;
  logic              arm_wr, solo_wr, group_wr;
  logic [NUM_CH-1:0] pending, kill_vec;
  logic              done;
  logic [CW-1:0]     done_ch;
  logic [2:0]        fetch_idx;
  desc_t             desc;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign arm_wr   = reg_wr_en && (reg_wr_sel == SEL_ARM);
  assign solo_wr  = reg_wr_en && (reg_wr_sel == SEL_BASE_SOLO);
  assign group_wr = reg_wr_en && (reg_wr_sel == SEL_BASE_GROUP);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  base_solo_q <= '0;
    else if (solo_wr) base_solo_q <= reg_wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   base_group_q <= '0;
    else if (group_wr) base_group_q <= reg_wr_data;
  end

  dma_arm_ctrl #(.NUM_CH(NUM_CH), .DW(AW), .ABORT_BIT(ABORT_BIT), .CW(CW)) u_arm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .arm_wr  (arm_wr),
    .wr_data (reg_wr_data),
    .done    (done),
    .done_ch (done_ch),
    .armed   (ch_armed),
    .ready   (ch_ready),
    .pending (pending),
    .kill_vec(kill_vec)
  );

  dma_desc_fetch #(.NUM_CH(NUM_CH), .AW(AW), .CW(CW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pending   (pending),
    .kill_vec  (kill_vec),
    .base_solo (base_solo_q),
    .base_group(base_group_q),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .done      (done),
    .done_ch   (done_ch),
    .byte_idx  (fetch_idx),
    .desc      (desc)
  );

  dma_desc_store #(.NUM_CH(NUM_CH), .AW(AW), .CW(CW)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .done    (done),
    .done_ch (done_ch),
    .desc    (desc),
    .src_flat(ch_src),
    .dst_flat(ch_dst),
    .len_flat(ch_len),
    .word    (ch_word)
  );

endmodule

// File: rtl/dma_desc_loader_chk.sv
module dma_desc_loader_chk #(
  parameter int NUM_CH    = 5,
  parameter int AW        = 16,
  parameter int ABORT_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [1:0]        reg_wr_sel,
  input logic [AW-1:0]     reg_wr_data,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [AW-1:0]     mem_addr,
  input logic [2:0]        fetch_idx,
  input logic [NUM_CH-1:0] ch_armed,
  input logic [NUM_CH-1:0] ch_ready
);

  logic              abort_wr;
  logic [NUM_CH-1:0] abort_mask;

  assign abort_wr   = reg_wr_en && (reg_wr_sel == 2'd0) && reg_wr_data[ABORT_BIT];
  assign abort_mask = reg_wr_data[NUM_CH-1:0];

  AST_READY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ready & ~ch_armed) == '0); // R11

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !abort_wr) |=> (mem_req && $stable(mem_addr))); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && fetch_idx != 3'd7 && !abort_wr)
      |=> (mem_req && mem_addr == $past(mem_addr) + AW'(1))); // R5

  AST_READY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_ready & ~$past(ch_ready))) |-> $past(mem_req && mem_gnt)); // R7

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (((ch_armed | ch_ready) & $past(abort_mask)) == '0)); // R9

endmodule

bind dma_desc_loader dma_desc_loader_chk #(
  .NUM_CH(NUM_CH), .AW(AW), .ABORT_BIT(ABORT_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_sel (reg_wr_sel),
  .reg_wr_data(reg_wr_data),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .fetch_idx  (fetch_idx),
  .ch_armed   (ch_armed),
  .ch_ready   (ch_ready)
);

// File: tb/dma_desc_loader_test.sv
module dma_desc_loader_test;

  localparam int NUM_CH = 5;
  localparam int AW     = 16;

  typedef struct packed {
    logic [2:0]  ch;
    logic [15:0] base;
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  len;
    logic [7:0]  cfg;
    logic [7:0]  exp_len;
  } vec_t;

  // cfg bit0 = word, bit1 = full 8-bit length
  localparam vec_t VECS [6] = '{
    '{3'd0, 16'h0010, 16'h1234, 16'hABCD, 8'hF5, 8'h00, 8'h75},
    '{3'd1, 16'h0040, 16'h2001, 16'h3002, 8'hF5, 8'h02, 8'hF5},
    '{3'd2, 16'h0040, 16'h4455, 16'h6677, 8'h9C, 8'h01, 8'h9C},
    '{3'd4, 16'h0080, 16'h0F0F, 16'hF0F0, 8'h80, 8'h00, 8'h00},
    '{3'd3, 16'h0083, 16'hBEEF, 16'hCAFE, 8'h7F, 8'h03, 8'h7F},
    '{3'd0, 16'h00F0, 16'h8001, 16'h0180, 8'hFF, 8'h01, 8'hFF}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n;
  logic                 reg_wr_en;
  logic [1:0]           reg_wr_sel;
  logic [AW-1:0]        reg_wr_data;
  logic                 mem_req;
  logic [AW-1:0]        mem_addr;
  logic                 mem_gnt;
  logic [7:0]           mem_rdata;
  logic [NUM_CH-1:0]    ch_armed, ch_ready, ch_word;
  logic [NUM_CH*AW-1:0] ch_src, ch_dst;
  logic [NUM_CH*8-1:0]  ch_len;

  dma_desc_loader uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .ch_armed(ch_armed),
    .ch_ready(ch_ready), .ch_word(ch_word), .ch_src(ch_src), .ch_dst(ch_dst),
    .ch_len(ch_len)
  );

  logic [7:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  logic gnt_en = 1'b0, gnt_alt = 1'b0, gnt_phase = 1'b0;
  always @(negedge clk) gnt_phase <= ~gnt_phase;
  assign mem_gnt = gnt_en && (!gnt_alt || gnt_phase);

  logic [15:0] log_a [0:63];
  int          log_n = 0;
  logic        log_clr = 1'b0;
  always @(posedge clk) begin
    if (log_clr) log_n <= 0;
    else if (mem_req && mem_gnt && log_n < 64) begin
      log_a[log_n] <= mem_addr;
      log_n <= log_n + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic load_desc(input logic [15:0] a, input logic [15:0] s, input logic [15:0] d,
                           input logic [7:0] l, input logic [7:0] c);
    mem[a[7:0]]      = s[7:0];
    mem[a[7:0] + 1]  = s[15:8];
    mem[a[7:0] + 2]  = d[7:0];
    mem[a[7:0] + 3]  = d[15:8];
    mem[a[7:0] + 4]  = l;
    mem[a[7:0] + 5]  = c;
    mem[a[7:0] + 6]  = 8'hEE;
    mem[a[7:0] + 7]  = 8'hEE;
  endtask

  task automatic clear_log();
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
  endtask

  task automatic wait_ready(input logic [NUM_CH-1:0] m);
    for (int k = 0; k < 200; k++) begin
      if ((ch_ready & m) == m) break;
      @(negedge clk);
    end
  endtask

  // checks that log entries [from, from+8) hold a..a+7
  function automatic bit log_match(input int from, input logic [15:0] a);
    for (int k = 0; k < 8; k++)
      if (log_a[from + k] !== a + 16'(k)) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t       t;
    logic [15:0] a;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0;
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(ch_armed == '0 && ch_ready == '0 && mem_req == 1'b0, "R1",
          {ch_armed, ch_ready, mem_req}, 0);

    gnt_en = 1'b1;
    // table walk: R3 R4 R5 R7 R8
    for (int v = 0; v < 6; v++) begin
      t = VECS[v];
      gnt_alt = v[0];
      reg_write(2'd0, 16'h0080 | (16'd1 << t.ch));
      reg_write((t.ch == 0) ? 2'd1 : 2'd2, t.base);
      a = (t.ch == 0) ? t.base : t.base + 16'(8 * (int'(t.ch) - 1));
      load_desc(a, t.src, t.dst, t.len, t.cfg);
      clear_log();
      reg_write(2'd0, 16'd1 << t.ch);
      wait_ready(NUM_CH'(1) << t.ch);
      check(ch_ready[t.ch] == 1'b1, "R7 ready", ch_ready, NUM_CH'(1) << t.ch);
      check(log_n == 8 && log_match(0, a), (t.ch == 0) ? "R3 addr" : "R4/R5 addr",
            {16'(log_n), log_a[0]}, {16'd8, a});
      check(ch_src[t.ch*16 +: 16] == t.src && ch_dst[t.ch*16 +: 16] == t.dst
            && ch_word[t.ch] == t.cfg[0], "R7 fields",
            {ch_src[t.ch*16 +: 16], ch_dst[t.ch*16 +: 16], 7'd0, ch_word[t.ch]},
            {t.src, t.dst, 7'd0, t.cfg[0]});
      check(ch_len[t.ch*8 +: 8] == t.exp_len, "R8 len", ch_len[t.ch*8 +: 8], t.exp_len);
    end

    // R2 / R6: arm three channels at once
    gnt_alt = 1'b0;
    reg_write(2'd0, 16'h009F);
    check(ch_armed == '0 && ch_ready == '0, "R9 abort all", {ch_armed, ch_ready}, 0);
    reg_write(2'd1, 16'h0010);
    reg_write(2'd2, 16'h0040);
    load_desc(16'h0010, 16'h1111, 16'h2222, 8'h05, 8'h00);
    load_desc(16'h0040, 16'h3333, 16'h4444, 8'h06, 8'h00);
    load_desc(16'h0048, 16'h5555, 16'h6666, 8'h07, 8'h00);
    load_desc(16'h0050, 16'h7777, 16'h8888, 8'h08, 8'h00);
    load_desc(16'h0058, 16'h9999, 16'hAAAA, 8'h09, 8'h00);
    clear_log();
    reg_write(2'd0, 16'h000B);
    check(ch_armed == 5'b01011, "R2 arm mask", ch_armed, 5'b01011);
    wait_ready(5'b01011);
    check(log_n == 24 && log_match(0, 16'h0010) && log_match(8, 16'h0040)
          && log_match(16, 16'h0050), "R6 order",
          {16'(log_n), log_a[8], log_a[16]}, {16'd24, 16'h0040, 16'h0050});
    reg_write(2'd0, 16'h0004);
    check(ch_armed == 5'b01111 && (ch_ready & 5'b01011) == 5'b01011, "R2 others kept",
          {ch_armed, ch_ready}, {5'b01111, 5'b01011});
    wait_ready(5'b00100);
    reg_write(2'd0, 16'h0083);
    check(ch_armed == 5'b01100 && ch_ready == 5'b01100, "R9 selective abort",
          {ch_armed, ch_ready}, {5'b01100, 5'b01100});

    // R10: abort channel 4 mid-fetch
    gnt_en = 1'b0;
    reg_write(2'd0, 16'h0010);
    @(negedge clk);
    check(mem_req == 1'b1 && mem_addr == 16'h0058, "R4 stalled fetch start",
          {mem_req, mem_addr}, {1'b1, 16'h0058});
    gnt_en = 1'b1;
    repeat (3) @(negedge clk);
    gnt_en = 1'b0;
    reg_write(2'd0, 16'h0090);
    check(mem_req == 1'b0 && ch_armed[4] == 1'b0 && ch_ready[4] == 1'b0, "R10 cancel",
          {mem_req, ch_armed[4], ch_ready[4]}, 0);
    gnt_en = 1'b1;
    repeat (20) @(negedge clk);
    check(ch_ready[4] == 1'b0 && mem_req == 1'b0, "R10 stays idle", {ch_ready[4], mem_req}, 0);
    check(ch_ready == 5'b01100, "R9 neighbours kept", ch_ready, 5'b01100);
    clear_log();
    reg_write(2'd0, 16'h0010);
    wait_ready(5'b10000);
    check(log_n == 8 && log_match(0, 16'h0058) && ch_src[4*16 +: 16] == 16'h9999,
          "R10 refetch", {16'(log_n), log_a[0], ch_src[4*16 +: 16]},
          {16'd8, 16'h0058, 16'h9999});

    // R1 reset in the middle of activity
    rst_n = 1'b0;
    @(negedge clk);
    check(ch_armed == '0 && ch_ready == '0 && mem_req == 1'b0, "R1 mid reset",
          {ch_armed, ch_ready, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule